// File: doc/BRIEF.md
# Bit Permutation and Shift Unit

This unit is the shift and permutation stage of an integer datapath. Each cycle it takes a data operand, a control operand and a 3-bit operation code. It returns one XLEN-wide result. The operations are the three base shifts (left logical, right logical, right arithmetic), rotate right, generalized reverse, shuffle and unshuffle. Because it covers the base shifts, it can stand in place of a separate base shifter. The result is computed in one cycle and captured in a result register that an asynchronous active-low reset clears.

XLEN is 32 or 64. On a 64-bit build a word-select input turns on the 32-bit word forms. In a word form the operation runs on the low half with the narrower control field, and the 32-bit result is sign-extended to the full width. The datapath has two parts. A logarithmic barrel stage handles the shifts and the rotate, and left shifts reuse the right-shift stages by mirroring the data. Generalized reverse is a butterfly of conditional block swaps. The shuffle pair uses a per-bit index mapping. The unit has no states: every operation completes in the cycle it is presented.

Top module: `bp_perm_shift_unit`

## Requirements
- R1: While `rst_n` is low, `result` is zero. Otherwise `result` shows, one rising clock edge later, the value computed from the inputs sampled at that edge.
- R2: Operation code 3 (rotate right) moves input bit i to output bit (i − s) mod XLEN. Here s is the low log2(XLEN) bits of the control operand.
- R3: Operation code 4 (generalized reverse) moves input bit i to output bit i XOR c. Here c is the low log2(XLEN) bits of the control operand.
- R4: Operation code 5 (shuffle) sets output bit i from input bit m(k,i). Here k = control & (XLEN/2 − 1), and m(k,i) = ((k + (i & k & ~(k<<1))) & ~k) | (i & ~(k | (k<<1))) | ((i>>1) & k).
- R5: Operation code 6 (unshuffle) sends input bit i to output bit m(k,i), with k and m as in R4. Unshuffle applied to a shuffle result with the same k returns the original data.
- R6: Operation code 0 (shift left logical) moves input bit i to bit i + s and fills the vacated low bits with zero.
- R7: Operation code 1 (shift right logical) fills the vacated high bits with zero. Operation code 2 (shift right arithmetic) fills them with the input's top bit.
- R8: Control bits above the field an operation uses have no effect on the result.
- R9: On a 64-bit build with `word_sel` high, the operation runs on bits 31:0 with XLEN taken as 32 in R2 to R8. Bit 31 of that result is copied into bits 63:32. On a 32-bit build `word_sel` has no effect.
- R10: A control field of zero returns the data operand unchanged for operation codes 0 to 6.
- R11: Operation code 7 produces an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the result register captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| op_sel | input | 3 | Operation code: 0 sll, 1 srl, 2 sra, 3 ror, 4 grev, 5 shfl, 6 unshfl, 7 zero |
| word_sel | input | 1 | Selects the 32-bit word form (64-bit builds only) |
| src_data | input | XLEN | Data operand |
| ctl_data | input | XLEN | Shift amount or permutation control |
| result | output | XLEN | Registered result |

## Verification
The word form and the arithmetic fill can act in the same cycle. A word right-arithmetic shift of a value whose bit 31 is set fills bits 31 down to 32 − s inside the narrow lane. The widening step then fills bits 63:32 from that same bit 31. The bench provokes this with a directed vector and with random word-mode operands. It judges the result against a per-bit index model: each output bit is placed from its source bit, and the sign extension is added separately. An off-by-one in either fill shows as a wrong boundary bit. A shuffle followed by an unshuffle is also run for every k, and the original data must come back.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [2:0] {
        BP_SLL    = 3'd0,
        BP_SRL    = 3'd1,
        BP_SRA    = 3'd2,
        BP_ROR    = 3'd3,
        BP_GREV   = 3'd4,
        BP_SHFL   = 3'd5,
        BP_UNSHFL = 3'd6,
        BP_NONE   = 3'd7
    } bp_op_e;

    // Index of the bit that lands in the interleaved position i for stage mask k
    function automatic int bp_unperm(input int k, input int i);
        int keep_lo;
        int move_up;
        int move_dn;
        keep_lo = i & ~(k | (k << 1));
        move_up = (k + (i & k & ~(k << 1))) & ~k;
        move_dn = (i >> 1) & k;
        return move_up | keep_lo | move_dn;
    endfunction

endpackage

// File: rtl/bp_shift_unit.sv
module bp_shift_unit #(
    parameter int W = 64
) (
    input  logic [W-1:0]          data,
    input  logic [$clog2(W)-1:0]  amt,
    input  bp_pkg::bp_op_e        op,
    output logic [W-1:0]          y
);
    import bp_pkg::*;

    localparam int IW = $clog2(W);

    function automatic logic [W-1:0] mirror(input logic [W-1:0] x);
        logic [W-1:0] r;
        for (int j = 0; j < W; j++) begin
            r[W-1-j] = x[j];
        end
        return r;
    endfunction

    logic         go_left;
    logic         wrap;
    logic         fill;
    logic [W-1:0] stg [IW+1];
    logic [W-1:0] right_out;

    assign go_left = (op == BP_SLL);
    assign wrap    = (op == BP_ROR);
    assign fill    = (op == BP_SRA) & data[W-1];
    assign stg[0]  = go_left ? mirror(data) : data;

    // Logarithmic right shifter; stage s moves by 2**s when amt[s] is set
    for (genvar s = 0; s < IW; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [W-1:0] moved;
        assign moved = wrap ? {stg[s][SH-1:0], stg[s][W-1:SH]}
                            : {{SH{fill}}, stg[s][W-1:SH]};
        assign stg[s+1] = amt[s] ? moved : stg[s];
    end

    assign right_out = stg[IW];
    assign y = go_left ? mirror(right_out) : right_out;

endmodule

// File: rtl/bp_grev_unit.sv
module bp_grev_unit #(
    parameter int W = 64
) (
    input  logic [W-1:0]          data,
    input  logic [$clog2(W)-1:0]  ctl,
    output logic [W-1:0]          y
);
    localparam int IW = $clog2(W);

    // Bits whose index has bit s clear (lower half of each 2**(s+1) block)
    function automatic logic [W-1:0] lo_mask(input int s);
        logic [W-1:0] m;
        for (int j = 0; j < W; j++) begin
            m[j] = ((j >> s) & 1) == 0;
        end
        return m;
    endfunction

    logic [W-1:0] stg [IW+1];
    assign stg[0] = data;

    // Butterfly: stage s swaps neighbouring blocks of 2**s bits
    for (genvar s = 0; s < IW; s++) begin : g_bfly
        localparam int SH = 1 << s;
        localparam logic [W-1:0] LM = lo_mask(s);
        logic [W-1:0] swapped;
        assign swapped  = ((stg[s] & LM) << SH) | ((stg[s] >> SH) & LM);
        assign stg[s+1] = ctl[s] ? swapped : stg[s];
    end

    assign y = stg[IW];

endmodule

// File: rtl/bp_shuffle_unit.sv
module bp_shuffle_unit #(
    parameter int W = 64
) (
    input  logic [W-1:0]          data,
    input  logic [$clog2(W)-1:0]  ctl,
    input  logic                  inverse,
    output logic [W-1:0]          y
);
    localparam int IW = $clog2(W);

    logic unused_ctl_msb;
    assign unused_ctl_msb = ctl[IW-1];

    always_comb begin
        int              k;
        logic [IW-1:0]   idx;
        k = int'(ctl[IW-2:0]);
        y = '0;
        for (int i = 0; i < W; i++) begin
            idx = IW'(bp_pkg::bp_unperm(k, i));
            if (inverse) begin
                y[idx] = data[i];
            end else begin
                y[i] = data[idx];
            end
        end
    end

endmodule

// File: rtl/bp_lane.sv
module bp_lane #(
    parameter int W = 64
) (
    input  logic [W-1:0]          data,
    input  logic [$clog2(W)-1:0]  ctl,
    input  bp_pkg::bp_op_e        op,
    output logic [W-1:0]          y
);
    import bp_pkg::*;

    logic [W-1:0] shift_y;
    logic [W-1:0] grev_y;
    logic [W-1:0] shuf_y;

    bp_shift_unit #(.W(W)) u_shift (
        .data (data),
        .amt  (ctl),
        .op   (op),
        .y    (shift_y)
    );

    bp_grev_unit #(.W(W)) u_grev (
        .data (data),
        .ctl  (ctl),
        .y    (grev_y)
    );

    bp_shuffle_unit #(.W(W)) u_shuf (
        .data    (data),
        .ctl     (ctl),
        .inverse (op == BP_UNSHFL),
        .y       (shuf_y)
    );

    always_comb begin
        unique case (op)
            BP_SLL, BP_SRL, BP_SRA, BP_ROR: y = shift_y;
            BP_GREV:                        y = grev_y;
            BP_SHFL, BP_UNSHFL:             y = shuf_y;
            default:                        y = '0;
        endcase
    end

endmodule

// File: rtl/bp_perm_shift_unit.sv
module bp_perm_shift_unit #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op_sel,
    input  logic            word_sel,
    input  logic [XLEN-1:0] src_data,
    input  logic [XLEN-1:0] ctl_data,
    output logic [XLEN-1:0] result
);
    import bp_pkg::*;

    localparam int IW = $clog2(XLEN);

    bp_op_e          op_e;
    logic [XLEN-1:0] full_y;
    logic [XLEN-1:0] next_y;
    logic            word_eff;
    logic            unused_ctl_hi;

    assign op_e          = bp_op_e'(op_sel);
    assign unused_ctl_hi = ^ctl_data[XLEN-1:IW];

    bp_lane #(.W(XLEN)) u_full (
        .data (src_data),
        .ctl  (ctl_data[IW-1:0]),
        .op   (op_e),
        .y    (full_y)
    );

    if (XLEN == 64) begin : g_word
        logic [31:0] word_y;

        bp_lane #(.W(32)) u_word (
            .data (src_data[31:0]),
            .ctl  (ctl_data[4:0]),
            .op   (op_e),
            .y    (word_y)
        );

        assign word_eff = word_sel;
        assign next_y   = word_sel ? {{32{word_y[31]}}, word_y} : full_y;

        // R9
        word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && word_sel) |-> (result[63:32] == {32{result[31]}}));
    end else begin : g_noword
        logic unused_word_sel;
        assign unused_word_sel = word_sel;
        assign word_eff        = 1'b0;
        assign next_y          = full_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else begin
            result <= next_y;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0));

    // R10
    zero_ctl_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !word_eff && (op_sel != 3'd7) && (ctl_data[IW-1:0] == '0))
        |-> (result == $past(src_data)));

    // R7
    sra_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !word_eff && (op_sel == 3'd2) && src_data[XLEN-1] &&
              (ctl_data[IW-1:0] != '0))
        |-> (result[XLEN-1:XLEN-2] == 2'b11));

    // R6
    sll_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !word_eff && (op_sel == 3'd0) && (ctl_data[IW-1:0] != '0))
        |-> (result[0] == 1'b0));

    // R2
    perm_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !word_eff && (op_sel >= 3'd3) && (op_sel <= 3'd6))
        |-> ($countones(result) == $countones($past(src_data))));

    // R11
    none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && (op_sel == 3'd7)) |-> (result == '0));

endmodule

// File: tb/bp_perm_shift_unit_tb_top.sv
`timescale 1ns/1ps
module bp_perm_shift_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        word_sel = 1'b0;
    logic [63:0] src_data = '0;
    logic [63:0] ctl_data = '0;
    logic [63:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bp_perm_shift_unit #(.XLEN(64)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_sel   (op_sel),
        .word_sel (word_sel),
        .src_data (src_data),
        .ctl_data (ctl_data),
        .result   (result)
    );

    // {op, word, data, control, expected}
    localparam int NV = 15;
    localparam logic [195:0] VEC [NV] = '{
        {3'd3, 1'b0, 64'h1, 64'd1, 64'h8000_0000_0000_0000},                      // R2
        {3'd3, 1'b0, 64'h1, 64'h41, 64'h8000_0000_0000_0000},                     // R8
        {3'd4, 1'b0, 64'h1, 64'd63, 64'h8000_0000_0000_0000},                     // R3
        {3'd4, 1'b0, 64'h1, 64'd7, 64'h80},                                       // R3
        {3'd5, 1'b0, 64'h2, 64'd1, 64'h4},                                        // R4
        {3'd6, 1'b0, 64'h4, 64'd1, 64'h2},                                        // R5
        {3'd0, 1'b0, 64'hF, 64'd4, 64'hF0},                                       // R6
        {3'd1, 1'b0, 64'h8000_0000_0000_0000, 64'd4, 64'h0800_0000_0000_0000},    // R7
        {3'd2, 1'b0, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000},    // R7
        {3'd2, 1'b1, 64'h8000_0000, 64'd4, 64'hFFFF_FFFF_F800_0000},              // R9
        {3'd3, 1'b1, 64'h1, 64'd1, 64'hFFFF_FFFF_8000_0000},                      // R9
        {3'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 64'h0},                      // R11
        {3'd4, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'd0, 64'h1234_5678_9ABC_DEF0},    // R10
        {3'd1, 1'b1, 64'hFFFF_FFFF_0000_0002, 64'h21, 64'h1},                     // R9
        {3'd5, 1'b0, 64'h2, 64'h21, 64'h4}                                        // R8
    };

    function automatic int ref_map(input int k, input int i);
        return ((k + (i & k & ~(k << 1))) & ~k) | (i & ~(k | (k << 1))) | ((i >> 1) & k);
    endfunction

    // Per-bit index model of every operation
    function automatic logic [63:0] ref_op(input int op, input bit w,
                                           input logic [63:0] a, input logic [63:0] b);
        int          wd;
        int          s;
        int          k;
        logic [63:0] r;
        wd = w ? 32 : 64;
        s  = int'(b[5:0]) & (wd - 1);
        k  = int'(b[5:0]) & (wd / 2 - 1);
        r  = '0;
        for (int i = 0; i < wd; i++) begin
            case (op)
                0: if (i + s < wd) r[i + s] = a[i];
                1: if (i >= s) r[i - s] = a[i];
                2: begin
                    if (i >= s) r[i - s] = a[i];
                    if (i >= wd - s) r[i] = a[wd - 1];
                end
                3: r[(i - s) & (wd - 1)] = a[i];
                4: r[i ^ s] = a[i];
                5: r[i] = a[ref_map(k, i)];
                6: r[ref_map(k, i)] = a[i];
                default: r = '0;
            endcase
        end
        if (w) r[63:32] = {32{r[31]}};
        return r;
    endfunction

    function automatic string req_of(input int op, input bit w);
        if (w) return "R9";
        case (op)
            0: return "R6";
            1, 2: return "R7";
            3: return "R2";
            4: return "R3";
            5: return "R4";
            6: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input int op, input bit w, input logic [63:0] a,
                         input logic [63:0] b, output logic [63:0] got);
        @(negedge clk);
        op_sel   = 3'(op);
        word_sel = w;
        src_data = a;
        ctl_data = b;
        @(negedge clk);
        got = result;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] got;
        logic [63:0] mid;
        logic [63:0] a;
        logic [63:0] b;

        src_data = 64'hDEAD_BEEF_0123_4567;
        ctl_data = 64'd3;
        repeat (3) @(negedge clk);
        check("R1 reset", result, 64'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            apply(int'(VEC[v][195:193]), VEC[v][192], VEC[v][191:128], VEC[v][127:64], got);
            check(req_of(int'(VEC[v][195:193]), VEC[v][192]), got, VEC[v][63:0]);
        end

        // R10: zero control is identity for every real operation
        for (int op = 0; op < 7; op++) begin
            a = {$urandom, $urandom};
            apply(op, 1'b0, a, 64'hFFFF_FFFF_FFFF_FFC0, got);
            check("R10", got, a);
        end

        // Random comparison against the index model
        for (int n = 0; n < 400; n++) begin
            int op;
            bit w;
            op = int'($urandom % 8);
            w  = ($urandom % 4) == 0;
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            apply(op, w, a, b, got);
            check(req_of(op, w), got, ref_op(op, w, a, b));
        end

        // R5: unshuffle undoes shuffle for every k, full and word width
        for (int k = 0; k < 32; k++) begin
            a = {$urandom, $urandom};
            apply(5, 1'b0, a, 64'(k), mid);
            apply(6, 1'b0, mid, 64'(k), got);
            check("R5 roundtrip", got, a);
        end
        for (int k = 0; k < 16; k++) begin
            a = {32'h0, $urandom};
            apply(5, 1'b1, a, 64'(k), mid);
            apply(6, 1'b1, mid, 64'(k), got);
            check("R5 word roundtrip", got, {{32{a[31]}}, a[31:0]});
        end

        // R9 with R7: word arithmetic shift, sign fill meets sign extension
        apply(2, 1'b1, 64'h0000_0000_9000_0000, 64'd31, got);
        check("R9 word sra", got, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(2, 1'b1, 64'hFFFF_FFFF_7000_0000, 64'd3, got);
        check("R9 word sra pos", got, 64'h0000_0000_0E00_0000);

        // R1: asynchronous reset mid-run clears the result
        apply(0, 1'b0, 64'h1, 64'd1, got);
        check("R6", got, 64'h2);
        #1 rst_n = 1'b0;
        #1 check("R1 async clear", result, 64'h0);
        @(negedge clk);
        check("R1 held", result, 64'h0);
        rst_n = 1'b1;

        finish_run();
    end

endmodule